// File: doc/BRIEF.md
# Clock-Windowed Quad-Lane Serial Burst Slave

This block is a four-lane serial slave that works inside a burst of fixed shape. An external master drives the burst. While chip select is low, the slave counts serial clock periods from the falling edge of chip select. The burst has three parts, and the count decides which part is current. The master first sends write nibbles. A programmable number of idle turnaround clocks follows. Then come reply clocks, during which the slave drives the four data lines. Four configuration inputs set the burst shape: write length, turnaround length, window offset and reply length, all counted in serial clocks.

The window offset moves this slave's slots inside both the write part and the reply part. Several slaves can therefore share one burst, and each one listens to and answers in its own slice. All pins are brought into the core clock domain through synchronisers. The serial clock may run at up to 20 MHz when the core clock is well above that. Received nibbles are packed into bytes, high nibble first, and appear on a byte-wide output with a one-cycle strobe. Reply bytes are taken from a byte-wide input, and a one-cycle pulse reports each byte consumed.

Top module: `qspi_win_slave`

## Requirements
- R1: After reset, `spi_io_oe`, `rx_valid` and `tx_load` are all 0.
- R2: In the write part, the four lanes are sampled on each rising serial clock edge. Two consecutive own-window nibbles form one byte, with the first nibble in bits 7:4. The byte is presented on `rx_byte` together with a `rx_valid` pulse that lasts exactly one core cycle.
- R3: Only clock indices from `cfg_skip` up to `cfg_wr_len`-1 (index 0 is the first clock after chip select falls) are received. A final unpaired nibble in that range is discarded.
- R4: During turnaround clocks the slave neither captures data nor drives the lanes.
- R5: `spi_io_oe` is 1 exactly for clock indices from S = `cfg_wr_len`+`cfg_dummy`+`cfg_skip` up to S+`cfg_reply_len`-1. The lanes are set up after the preceding falling serial clock edge, so the master sees valid data at the rising edge of each such clock.
- R6: Reply clock S+2k carries bits 7:4 of a byte, and clock S+2k+1 carries bits 3:0 of the same byte. The byte is taken from `tx_byte` when its first nibble is prepared, and `tx_load` pulses for one core cycle for each byte taken.
- R7: When `spi_cs_n` is high, `spi_io_oe` is 0 without waiting for any clock.
- R8: A chip-select rise at any point aborts the burst. The clock count and any half-assembled byte are cleared, so the next burst starts again from index 0.
- R9: When S is 0, the first reply nibble is driven in response to the chip-select fall itself, before any serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_cs_n | input | 1 | Chip select from the master, active low |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_io_in | input | 4 | Lane inputs |
| spi_io_out | output | 4 | Lane outputs during the reply window |
| spi_io_oe | output | 1 | Lane output enable |
| cfg_wr_len | input | 8 | Write part length in clocks |
| cfg_dummy | input | 8 | Turnaround length in clocks |
| cfg_skip | input | 8 | Offset of this slave's slots in clocks |
| cfg_reply_len | input | 8 | Reply window length in clocks |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| tx_byte | input | 8 | Next reply byte |
| tx_load | output | 1 | One-cycle pulse when `tx_byte` has been taken |

## Verification
The hardest situations to reach from the ports are a burst cut short in the middle of a byte and a reply window that opens at index zero. In the first case stale counter or nibble state would only show up in the following burst. In the second, the nibble has to come from the chip-select edge alone. The bench plays the master. It drives one burst that ends after an odd number of write clocks and another that ends inside the reply window, and follows each with a full burst whose expected bytes hold only if everything restarted at index 0. A separate burst with zero write, turnaround and offset lengths checks the first nibble before any clock edge.

// File: rtl/qspi_win_pkg.sv
package qspi_win_pkg;
  localparam int QW_LANES  = 4;
  localparam int QW_B_CS   = 0;
  localparam int QW_B_SCLK = 1;
  localparam int QW_B_IO   = 2;
  localparam int QW_SYNC_W = QW_B_IO + QW_LANES;
endpackage

// File: rtl/qspi_win_sync.sv
module qspi_win_sync #(
  parameter int W = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/qspi_win_rx.sv
module qspi_win_rx #(
  parameter int CFG_W = 8,
  parameter int CNT_W = 10,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [CFG_W-1:0]   cfg_skip,
  input  logic [CFG_W-1:0]   cfg_wr_len,
  input  logic [LANES-1:0]   nib,
  output logic [2*LANES-1:0] rx_byte,
  output logic               rx_valid
);
  localparam int PADW = CNT_W - CFG_W;

  logic [CNT_W-1:0]   lo_x, hi_x;
  logic               hit, second;
  logic               hi_en, byte_en;
  logic [LANES-1:0]   hi_q;
  logic [2*LANES-1:0] byte_q, byte_d;
  logic               valid_q, valid_d;

  always_comb begin
    lo_x    = {{PADW{1'b0}}, cfg_skip};
    hi_x    = {{PADW{1'b0}}, cfg_wr_len};
    hit     = smp && (cnt >= lo_x) && (cnt < hi_x);
    second  = cnt[0] ^ cfg_skip[0];
    hi_en   = hit && !second;
    byte_en = hit && second;
    byte_d  = {hi_q, nib};
    valid_d = byte_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (hi_en)   hi_q   <= nib;
      if (byte_en) byte_q <= byte_d;
    end
  end

  assign rx_byte  = byte_q;
  assign rx_valid = valid_q;
endmodule

// File: rtl/qspi_win_tx.sv
module qspi_win_tx #(
  parameter int CFG_W = 8,
  parameter int CNT_W = 10,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt,
  input  logic               cs_lvl,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [CFG_W-1:0]   cfg_wr_len,
  input  logic [CFG_W-1:0]   cfg_dummy,
  input  logic [CFG_W-1:0]   cfg_skip,
  input  logic [CFG_W-1:0]   cfg_reply_len,
  input  logic [2*LANES-1:0] tx_byte,
  output logic               oe,
  output logic [LANES-1:0]   io,
  output logic               tx_load
);
  localparam int PADW = CNT_W - CFG_W;

  logic [CNT_W-1:0] start_x, stop_x;
  logic             hit, odd, upd;
  logic             oe_q, oe_d;
  logic [LANES-1:0] io_q, io_d, lo_q, lo_d;
  logic             load_q, load_d;

  always_comb begin
    start_x = {{PADW{1'b0}}, cfg_wr_len} + {{PADW{1'b0}}, cfg_dummy}
            + {{PADW{1'b0}}, cfg_skip};
    stop_x  = start_x + {{PADW{1'b0}}, cfg_reply_len};
    hit     = (cnt >= start_x) && (cnt < stop_x);
    odd     = cnt[0] ^ start_x[0];
    upd     = cs_lvl | evt;
    oe_d    = oe_q;
    io_d    = io_q;
    lo_d    = lo_q;
    load_d  = 1'b0;
    if (cs_lvl) begin
      oe_d = 1'b0;
    end else if (evt) begin
      oe_d = hit;
      if (hit) begin
        if (!odd) begin
          io_d   = tx_byte[2*LANES-1:LANES];
          lo_d   = tx_byte[LANES-1:0];
          load_d = 1'b1;
        end else begin
          io_d = lo_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      io_q   <= '0;
      lo_q   <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= load_d;
      if (upd) begin
        oe_q <= oe_d;
        io_q <= io_d;
        lo_q <= lo_d;
      end
    end
  end

  assign oe      = oe_q;
  assign io      = io_q;
  assign tx_load = load_q;
endmodule

// File: rtl/qspi_win_slave.sv
module qspi_win_slave
  import qspi_win_pkg::*;
#(
  parameter int CFG_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_cs_n,
  input  logic                  spi_sclk,
  input  logic [QW_LANES-1:0]   spi_io_in,
  output logic [QW_LANES-1:0]   spi_io_out,
  output logic                  spi_io_oe,
  input  logic [CFG_W-1:0]      cfg_wr_len,
  input  logic [CFG_W-1:0]      cfg_dummy,
  input  logic [CFG_W-1:0]      cfg_skip,
  input  logic [CFG_W-1:0]      cfg_reply_len,
  output logic [2*QW_LANES-1:0] rx_byte,
  output logic                  rx_valid,
  input  logic [2*QW_LANES-1:0] tx_byte,
  output logic                  tx_load
);
  localparam int LANES = QW_LANES;
  localparam int CNT_W = CFG_W + 2;
  localparam int SW    = QW_SYNC_W;
  localparam logic [SW-1:0] SYNC_RST = {{LANES{1'b0}}, 1'b0, 1'b1};

  logic [1:0]       rst_pipe_q;
  logic             rst_l;
  logic [SW-1:0]    pin_vec, pin_lvl;
  logic             cs_lvl, cs_prv_q, sclk_lvl, sclk_prv_q;
  logic             cs_fall, sclk_rise, sclk_fall, tx_evt;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             tx_oe;
  logic [LANES-1:0] nib_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_l = rst_pipe_q[1];

  assign pin_vec = {spi_io_in, spi_sclk, spi_cs_n};

  qspi_win_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_l), .d(pin_vec), .q(pin_lvl)
  );

  assign cs_lvl   = pin_lvl[QW_B_CS];
  assign sclk_lvl = pin_lvl[QW_B_SCLK];
  assign nib_s    = pin_lvl[QW_B_IO +: LANES];

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      cs_prv_q   <= 1'b1;
      sclk_prv_q <= 1'b0;
    end else begin
      cs_prv_q   <= cs_lvl;
      sclk_prv_q <= sclk_lvl;
    end
  end

  always_comb begin
    cs_fall   = cs_prv_q & ~cs_lvl;
    sclk_rise = ~sclk_prv_q & sclk_lvl & ~cs_lvl;
    sclk_fall = sclk_prv_q & ~sclk_lvl & ~cs_lvl;
    tx_evt    = cs_fall | sclk_fall;
    cnt_en    = cs_lvl | sclk_rise;
    cnt_d     = cnt_q;
    if (cs_lvl)                   cnt_d = '0;
    else if (cnt_q != {CNT_W{1'b1}}) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  qspi_win_rx #(.CFG_W(CFG_W), .CNT_W(CNT_W), .LANES(LANES)) u_rx (
    .clk(clk), .rst_n(rst_l), .smp(sclk_rise), .cnt(cnt_q),
    .cfg_skip(cfg_skip), .cfg_wr_len(cfg_wr_len), .nib(nib_s),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  qspi_win_tx #(.CFG_W(CFG_W), .CNT_W(CNT_W), .LANES(LANES)) u_tx (
    .clk(clk), .rst_n(rst_l), .evt(tx_evt), .cs_lvl(cs_lvl), .cnt(cnt_q),
    .cfg_wr_len(cfg_wr_len), .cfg_dummy(cfg_dummy), .cfg_skip(cfg_skip),
    .cfg_reply_len(cfg_reply_len), .tx_byte(tx_byte),
    .oe(tx_oe), .io(spi_io_out), .tx_load(tx_load)
  );

  assign spi_io_oe = tx_oe & ~spi_cs_n;
endmodule

// File: rtl/qspi_win_slave_chk.sv
module qspi_win_slave_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_cs_n,
  input logic             cs_lvl,
  input logic [CNT_W-1:0] cnt_q,
  input logic             tx_oe,
  input logic             rx_valid,
  input logic             tx_load
);
  a_r2_rx_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_load_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);

  a_r6_load_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> tx_oe);

  a_r4_rx_not_in_reply: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !tx_oe);

  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_lvl) |=> (cnt_q == '0 && !tx_oe));

  a_r7_drive_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
     && $past(spi_cs_n, 4)) |-> !tx_oe);
endmodule

bind qspi_win_slave qspi_win_slave_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .cs_lvl(cs_lvl),
  .cnt_q(cnt_q), .tx_oe(tx_oe), .rx_valid(rx_valid), .tx_load(tx_load)
);

// File: tb/qspi_win_slave_bench.sv
module qspi_win_slave_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_cs_n, spi_sclk;
  logic [3:0] spi_io_in, spi_io_out;
  logic       spi_io_oe;
  logic [7:0] cfg_wr_len, cfg_dummy, cfg_skip, cfg_reply_len;
  logic [7:0] rx_byte, tx_byte;
  logic       rx_valid, tx_load;

  int n_checks = 0;
  int n_fail = 0;
  int tx_idx = 0;
  int tx_exp_total = 0;
  bit done = 1'b0;
  logic [7:0] exp_rx[$];

  always #4 clk = ~clk;

  qspi_win_slave u_qspi_win_slave (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_io_in(spi_io_in), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
    .cfg_wr_len(cfg_wr_len), .cfg_dummy(cfg_dummy), .cfg_skip(cfg_skip),
    .cfg_reply_len(cfg_reply_len), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .tx_byte(tx_byte), .tx_load(tx_load)
  );

  function automatic logic [7:0] rep_of(int k);
    return 8'((k * 37 + 91) & 255);
  endfunction

  function automatic logic [3:0] pat(int i, int seed);
    return 4'((i * 7 + seed * 3 + 5) & 15);
  endfunction

  assign tx_byte = rep_of(tx_idx);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: bytes from the slave against the queue
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_rx.size() == 0) begin
        chk(1'b0, "R3", "unexpected rx byte", int'(rx_byte), -1);
      end else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        chk(rx_byte == e, "R2", "rx byte", int'(rx_byte), int'(e));
      end
    end
    if (rst_n && tx_load) tx_idx++;
  end

  task automatic burst(input int wr, input int dm, input int sk, input int rl,
                       input int n, input int seed, input string post_req);
    int start;
    int loads;
    int base;
    start = wr + dm + sk;
    base  = tx_exp_total;
    loads = 0;
    for (int i = sk; (i + 1 < wr) && (i + 1 < n); i += 2)
      exp_rx.push_back({pat(i, seed), pat(i + 1, seed)});
    for (int c = 0; c <= n; c++)
      if (c >= start && c < start + rl && ((c - start) % 2) == 0) loads++;
    @(negedge clk);
    cfg_wr_len = 8'(wr); cfg_dummy = 8'(dm); cfg_skip = 8'(sk);
    cfg_reply_len = 8'(rl);
    spi_cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bit exp_oe;
      string r;
      spi_io_in = pat(i, seed);
      repeat (8) @(negedge clk);
      exp_oe = (i >= start) && (i < start + rl);
      r = (i < wr) ? "R5" : (i < wr + dm) ? "R4" : (start == 0 && i == 0) ? "R9" : "R5";
      chk(spi_io_oe == exp_oe, r, "lane enable", int'(spi_io_oe), int'(exp_oe));
      if (exp_oe) begin
        int off;
        logic [7:0] b;
        logic [3:0] en;
        off = i - start;
        b = rep_of(base + off / 2);
        en = (off % 2 == 0) ? b[7:4] : b[3:0];
        chk(spi_io_out == en, (start == 0 && i == 0) ? "R9" : "R6", "reply nibble",
            int'(spi_io_out), int'(en));
      end
      spi_sclk = 1'b1;
      repeat (8) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    spi_cs_n = 1'b1;
    #1;
    chk(spi_io_oe == 1'b0, "R7", "enable after cs rise", int'(spi_io_oe), 0);
    repeat (8) @(negedge clk);
    chk(exp_rx.size() == 0, post_req, "rx bytes missing", exp_rx.size(), 0);
    exp_rx.delete();
    tx_exp_total += loads;
    chk(tx_idx == tx_exp_total, "R6", "reply bytes taken", tx_idx, tx_exp_total);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_io_in = 4'h0;
    cfg_wr_len = 8'd0; cfg_dummy = 8'd0; cfg_skip = 8'd0; cfg_reply_len = 8'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(spi_io_oe == 1'b0, "R1", "reset enable", int'(spi_io_oe), 0);
    chk(rx_valid == 1'b0, "R1", "reset rx strobe", int'(rx_valid), 0);
    chk(tx_load == 1'b0, "R1", "reset load pulse", int'(tx_load), 0);

    // R2: plain burst, two write bytes, two reply bytes
    burst(4, 2, 0, 4, 10, 1, "R2");
    // R3, R4: offset window, trailing nibble dropped, odd reply length
    burst(7, 3, 2, 3, 15, 2, "R3");
    // R9: reply from clock zero
    burst(0, 0, 0, 4, 4, 3, "R9");
    // R8: abort after three write clocks, then a full burst
    burst(6, 1, 0, 4, 3, 4, "R8");
    burst(4, 1, 1, 2, 8, 5, "R8");
    // R7: abort inside the reply window, then a clean burst
    burst(2, 1, 0, 6, 5, 6, "R7");
    burst(2, 0, 1, 4, 7, 7, "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule